// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple clocked request port to an external 128K x 8 asynchronous static RAM. A requester presents an address, a write flag and write data together with `req_valid`. The controller takes the request when `req_ready` is high. It then sequences the memory's two chip selects (one active low, one active high), its write and output enables, the address bus and a bidirectional data bus. When the access is complete it raises a one-cycle `rsp_done` pulse. For reads, `rsp_rdata` holds the byte captured from the memory.

Every phase of an access lasts a whole number of clock cycles. Each phase length is the ceiling of the required nanosecond interval divided by the clock period (`CLK_PS`), and is never less than one cycle. The intervals come from a table selected by `GRADE_NS` (55, 70 or 100). The states are IDLE, W_TURN, W_STROBE, W_HOLD, R_ACCESS and FINISH. The transitions are:
- accept-write: IDLE to W_TURN
- accept-read: IDLE to R_ACCESS
- gap-elapsed: W_TURN to W_STROBE
- pulse-elapsed: W_STROBE to W_HOLD
- hold-elapsed: W_HOLD to FINISH
- data-captured: R_ACCESS to FINISH
- release: FINISH to IDLE

The memory is deselected whenever the controller is not in an access.

Top module: `sram_ctrl`

## Requirements
- R1: While idle, the controller holds the memory in standby: `mem_cs1_n`=1, `mem_cs2`=0, `mem_we_n`=1 and `mem_oe_n`=1.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the cycle after `rsp_done`.
- R3: In a write, `mem_we_n` is low only while `mem_cs1_n`=0, `mem_cs2`=1 and `mem_oe_n`=1. It is low for exactly N_WP cycles, with the request address on `mem_addr`. N_WP is the ceiling of max(write pulse, select-to-end, address-to-end, data-to-end) over the clock period.
- R4: The write byte is driven onto `mem_dq` for the whole write strobe and one cycle after it, so the memory stores the requested byte.
- R5: Before the write strobe starts, the memory is selected with both enables high for exactly N_OHZ cycles. N_OHZ is the ceiling of the output-disable-to-high-impedance time. The data driver is never enabled unless `mem_oe_n` has been high for at least N_OHZ cycles.
- R6: In a read, `mem_oe_n` is low and `mem_we_n` is high for exactly N_RD cycles, with selects and address stable. N_RD is the ceiling of max(read cycle, address access, output enable access).
- R7: `rsp_done` is a single-cycle pulse, one per access. For a read, `rsp_rdata` shows the byte the memory held at the address when `rsp_done` is high.
- R8: The latency from acceptance to `rsp_done` is N_OHZ+N_WP+N_HOLD cycles for a write and N_RD cycles for a read. N_HOLD = max(1, N_WC-N_OHZ-N_WP), where N_WC is the ceiling of the write cycle time.
- R9: Every phase length is at least one cycle. Each length is rounded up, never down, from the grade's nanosecond figure.
- R10: After reset, `req_ready`=1, `rsp_done`=0 and the memory is in standby.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Byte to write |
| rsp_rdata | output | DATA_W | Last byte read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq | inout | DATA_W | Bidirectional data bus |

## Verification
A state machine stuck or exited early shows at the memory pins within the phase concerned. The strobe width, the pre-strobe gap or the read-enable width then differs from its computed count, and the bench measures each of these on every access. A wrong data latch or drive window appears one access later, as a mismatched byte on `rsp_rdata` during a read-back. A misplaced completion shows as `rsp_done` arriving on a cycle other than the predicted latency, or as `req_ready` rising too early.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W_TURN,
        ST_W_STROBE,
        ST_W_HOLD,
        ST_R_ACCESS,
        ST_FINISH
    } ctrl_state_t;

    typedef struct packed {
        int unsigned wp_ns;
        int unsigned cw_ns;
        int unsigned aw_ns;
        int unsigned dw_ns;
        int unsigned rc_ns;
        int unsigned aa_ns;
        int unsigned oe_ns;
        int unsigned hz_ns;
        int unsigned wc_ns;
    } grade_times_t;

    function automatic grade_times_t grade_times(input int unsigned grade);
        grade_times_t t;
        case (grade)
            55: begin
                t.wp_ns = 40;  t.cw_ns = 45;  t.aw_ns = 45; t.dw_ns = 25;
                t.rc_ns = 55;  t.aa_ns = 55;  t.oe_ns = 25; t.hz_ns = 20;
                t.wc_ns = 55;
            end
            70: begin
                t.wp_ns = 50;  t.cw_ns = 60;  t.aw_ns = 60; t.dw_ns = 30;
                t.rc_ns = 70;  t.aa_ns = 70;  t.oe_ns = 35; t.hz_ns = 25;
                t.wc_ns = 70;
            end
            default: begin
                t.wp_ns = 60;  t.cw_ns = 80;  t.aw_ns = 80; t.dw_ns = 40;
                t.rc_ns = 100; t.aa_ns = 100; t.oe_ns = 50; t.hz_ns = 30;
                t.wc_ns = 100;
            end
        endcase
        return t;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Ceiling of ns / clock period, never below one cycle.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= len;
        end else if (cnt_q > 1) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The phase's last cycle is the one in which the count reads one.
    assign expire = (cnt_q <= 1);
endmodule

// File: rtl/sram_dq_io.sv
module sram_dq_io #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              drive,
    input  logic              capture,
    output logic [DATA_W-1:0] rdata,
    inout  wire  [DATA_W-1:0] dq
);
    logic [DATA_W-1:0] wbuf_q;
    logic [DATA_W-1:0] rbuf_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbuf_q <= '0;
        end else if (load) begin
            wbuf_q <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbuf_q <= '0;
        end else if (capture) begin
            rbuf_q <= dq;
        end
    end

    assign dq    = drive ? wbuf_q : {DATA_W{1'bz}};
    assign rdata = rbuf_q;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_PS   = 4000,
    parameter int GRADE_NS = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_dq
);
    localparam grade_times_t T = grade_times(GRADE_NS);
    localparam int unsigned N_OHZ  = ns_to_cycles(T.hz_ns, CLK_PS);
    localparam int unsigned N_WP   = ns_to_cycles(umax(umax(T.wp_ns, T.cw_ns),
                                                       umax(T.aw_ns, T.dw_ns)), CLK_PS);
    localparam int unsigned N_WC   = ns_to_cycles(T.wc_ns, CLK_PS);
    localparam int unsigned N_HOLD = (N_WC > N_OHZ + N_WP) ? (N_WC - N_OHZ - N_WP) : 1;
    localparam int unsigned N_RD   = ns_to_cycles(umax(umax(T.rc_ns, T.aa_ns), T.oe_ns),
                                                  CLK_PS);
    localparam int unsigned N_MAX  = umax(umax(N_OHZ, N_WP), umax(N_HOLD, N_RD));
    localparam int CNT_W = $clog2(N_MAX + 1);

    ctrl_state_t      state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic             take;
    logic             tmr_start;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_expire;
    logic             sel, we_act, oe_act, dq_drive, capture;

    assign take = req_valid && req_ready;

    // Next-state and timer-load logic
    always_comb begin
        state_d   = state_q;
        tmr_start = 1'b0;
        tmr_len   = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take && req_write) begin
                    state_d   = ST_W_TURN;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(N_OHZ);
                end else if (take) begin
                    state_d   = ST_R_ACCESS;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(N_RD);
                end
            end
            ST_W_TURN: begin
                if (tmr_expire) begin
                    state_d   = ST_W_STROBE;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(N_WP);
                end
            end
            ST_W_STROBE: begin
                if (tmr_expire) begin
                    state_d   = ST_W_HOLD;
                    tmr_start = 1'b1;
                    tmr_len   = CNT_W'(N_HOLD);
                end
            end
            ST_W_HOLD: begin
                if (tmr_expire) state_d = ST_FINISH;
            end
            ST_R_ACCESS: begin
                if (tmr_expire) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take) begin
            addr_q <= req_addr;
        end
    end

    // Output decode
    always_comb begin
        sel       = 1'b0;
        we_act    = 1'b0;
        oe_act    = 1'b0;
        dq_drive  = 1'b0;
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        capture   = 1'b0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_W_TURN:   sel = 1'b1;
            ST_W_STROBE: begin
                sel      = 1'b1;
                we_act   = 1'b1;
                dq_drive = 1'b1;
            end
            ST_W_HOLD: begin
                sel      = 1'b1;
                dq_drive = 1'b1;
            end
            ST_R_ACCESS: begin
                sel     = 1'b1;
                oe_act  = 1'b1;
                capture = tmr_expire;
            end
            ST_FINISH:   rsp_done = 1'b1;
            default: ;
        endcase
    end

    assign mem_cs1_n = ~sel;
    assign mem_cs2   = sel;
    assign mem_we_n  = ~we_act;
    assign mem_oe_n  = ~oe_act;
    assign mem_addr  = addr_q;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    sram_dq_io #(.DATA_W(DATA_W)) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (take),
        .wdata   (req_wdata),
        .drive   (dq_drive),
        .capture (capture),
        .rdata   (rsp_rdata),
        .dq      (mem_dq)
    );
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int CLK_PS   = 4000,
    parameter int GRADE_NS = 55
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              mem_cs1_n,
    input logic              mem_cs2,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              drive_en
);
    localparam grade_times_t T = grade_times(GRADE_NS);
    localparam int unsigned N_OHZ = ns_to_cycles(T.hz_ns, CLK_PS);
    localparam int CW = $clog2(N_OHZ + 2);

    logic [CW-1:0] oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_cnt <= '0;
        end else if (!mem_oe_n) begin
            oe_hi_cnt <= '0;
        end else if (oe_hi_cnt < CW'(N_OHZ)) begin
            oe_hi_cnt <= oe_hi_cnt + 1'b1;
        end
    end

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_strobe_selected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2 && mem_oe_n));

    p_drive_after_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> (mem_oe_n && oe_hi_cnt >= CW'(N_OHZ)));

    p_no_drive_while_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> mem_oe_n);

    p_read_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n && $past(!mem_oe_n)) |-> ($stable(mem_addr) && !mem_cs1_n && mem_cs2));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
endmodule

bind sram_ctrl sram_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .CLK_PS   (CLK_PS),
    .GRADE_NS (GRADE_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_cs1_n (mem_cs1_n),
    .mem_cs2   (mem_cs2),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_addr  (mem_addr),
    .drive_en  (dq_drive)
);

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int CLK_PS = 4000;
    localparam int GRADE = 55;

    // Expected cycle counts from the grade-55 figures at 4 ns
    function automatic int ceil_cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_OHZ  = 5;   // ceil(20/4)
    localparam int E_WP   = 12;  // ceil(45/4)
    localparam int E_WC   = 14;  // ceil(55/4)
    localparam int E_HOLD = 1;   // max(1, 14-5-12)
    localparam int E_RD   = 14;  // ceil(55/4)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_addr = '0;
    logic req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rsp_rdata;
    logic rsp_done;
    logic mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_dq;

    always #2 clk = ~clk;

    sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CLK_PS(CLK_PS), .GRADE_NS(GRADE)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    // Memory model
    logic [DW-1:0] mem [int];
    logic [DW-1:0] model_byte;
    logic model_drive;
    assign model_drive = !mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n;
    always_comb begin
        if (mem.exists(int'(mem_addr))) model_byte = mem[int'(mem_addr)];
        else model_byte = mem_addr[7:0] ^ 8'h5A;
    end
    assign mem_dq = model_drive ? model_byte : 8'bz;

    function automatic logic [DW-1:0] peek(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'(a) ^ 8'h5A;
    endfunction

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    typedef struct {
        bit          wr;
        int          addr;
        logic [7:0]  data;
        int          done_cyc;
    } item_t;
    item_t exp_q[$];
    logic [7:0] shadow [int];

    task automatic issue(input bit wr, input int addr, input logic [7:0] data);
        item_t it;
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'(addr);
        req_wdata = data;
        while (!req_ready) @(negedge clk);
        it.wr = wr;
        it.addr = addr;
        if (wr) begin
            it.data = data;
            shadow[addr] = data;
        end else begin
            it.data = shadow.exists(addr) ? shadow[addr] : (8'(addr) ^ 8'h5A);
        end
        it.done_cyc = cyc + 1 + (wr ? (E_OHZ + E_WP + E_HOLD) : E_RD);
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: pin timing and completions
    int we_run = 0, oe_run = 0, gap_run = 0;
    logic prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_cs1_n = 1'b1;
    int last_done = -10;
    always @(negedge clk) begin
        if (rst_n) begin
            if (req_ready)
                check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n, "R1 standby pins",
                      {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);
            if (exp_q.size() != 0 && !rsp_done && !req_valid)
                check(!req_ready, "R2 ready low while busy", req_ready, 0);
            // gap from select to strobe
            if (!mem_cs1_n && mem_we_n && mem_oe_n && prev_we_n) gap_run++;
            if (!mem_we_n && prev_we_n) begin
                check(gap_run == E_OHZ, "R5 turnaround gap", gap_run, E_OHZ);
                check(exp_q.size() != 0 && int'(mem_addr) == exp_q[0].addr,
                      "R3 strobe address", int'(mem_addr), exp_q.size() ? exp_q[0].addr : -1);
                check(mem_dq == exp_q[0].data, "R4 data on bus", mem_dq, exp_q[0].data);
            end
            if (!mem_we_n) we_run++;
            if (mem_we_n && !prev_we_n) begin
                check(we_run == E_WP, "R3 strobe width", we_run, E_WP);
                check(mem_dq == exp_q[0].data, "R4 data held after strobe", mem_dq, exp_q[0].data);
                we_run = 0;
            end
            if (!mem_oe_n) begin
                oe_run++;
                check(mem_we_n && !mem_cs1_n && mem_cs2, "R6 read controls",
                      {mem_we_n, mem_cs1_n, mem_cs2}, 3'b101);
            end
            if (mem_oe_n && !prev_oe_n) begin
                check(oe_run == E_RD, "R6 read enable width", oe_run, E_RD);
                oe_run = 0;
            end
            if (mem_cs1_n) gap_run = 0;
            // model write: latest value during strobe wins
            if (!mem_cs1_n && mem_cs2 && !mem_we_n) mem[int'(mem_addr)] = mem_dq;
            if (rsp_done) begin
                check(cyc != last_done + 1, "R7 done single pulse", cyc, last_done + 2);
                last_done = cyc;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    check(cyc == it.done_cyc, "R8 latency", cyc, it.done_cyc);
                    if (it.wr)
                        check(peek(it.addr) == it.data, "R4 memory stored byte",
                              peek(it.addr), it.data);
                    else
                        check(rsp_rdata == it.data, "R7 read data", rsp_rdata, it.data);
                end
            end
            prev_we_n  = mem_we_n;
            prev_oe_n  = mem_oe_n;
            prev_cs1_n = mem_cs1_n;
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        // R9: rounding up and one-cycle floor, from the grade figures
        check(ceil_cyc(20) == E_OHZ, "R9 gap rounds up", ceil_cyc(20), E_OHZ);
        check(ceil_cyc(45) == E_WP, "R9 strobe rounds up", ceil_cyc(45), E_WP);
        check(ceil_cyc(0) == 1, "R9 floor of one", ceil_cyc(0), 1);
        check(ceil_cyc(55) == E_WC && E_HOLD == 1, "R9 hold floor", ceil_cyc(55), E_WC);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        check(rsp_done == 1'b0, "R10 done after reset", rsp_done, 0);
        check(mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n, "R10 standby after reset",
              {mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n}, 4'b1011);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(req_ready && mem_cs1_n && !mem_cs2, "R1 idle with no request",
              {req_ready, mem_cs1_n, mem_cs2}, 3'b110);

        issue(1'b0, 17'h00010, '0);        // read unwritten location
        issue(1'b1, 17'h00000, 8'hA5);     // write lowest address
        issue(1'b1, 17'h1FFFF, 8'h3C);     // write highest address
        issue(1'b0, 17'h00000, '0);        // read back
        issue(1'b1, 17'h00000, 8'h00);     // read-to-write turnaround
        issue(1'b0, 17'h1FFFF, '0);
        issue(1'b0, 17'h00000, '0);
        for (int i = 0; i < 8; i++) issue(1'b1, 17'h0AA00 + i, 8'(i * 37 + 1));
        for (int i = 7; i >= 0; i--) issue(1'b0, 17'h0AA00 + i, '0);
        issue(1'b1, 17'h15555, 8'hFF);
        issue(1'b1, 17'h15555, 8'h81);     // overwrite
        issue(1'b0, 17'h15555, '0);

        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(req_ready && mem_cs1_n && !mem_cs2 && mem_oe_n, "R1 standby at end",
              {req_ready, mem_cs1_n, mem_cs2, mem_oe_n}, 4'b1101);
        finish_run();
    end
endmodule